// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder and NRZI Serializer

This block takes transmit nibbles from a MAC-side interface, qualified by a transmit-enable and an optional transmit-error flag, and turns them into a serial NRZI bit stream. Each nibble becomes a 5-bit code group. The block also manages the stream delimiters. When transmit-enable rises, the first two nibbles of the preamble are overwritten by the start pair /J/ /K/. When transmit-enable falls, the end pair /T/ /R/ takes the place of the first two idle groups. At all other times idle groups are sent.

The block runs on one clock, and a `bit_en` strobe marks each serial bit time, so five strobes make up one nibble period. The `nib_take` output tells the source that the next strobe will consume the nibble on the inputs. Inputs are sampled only on that edge. If the strobe is high on every bit time, the block gives five serial bits for each nibble, as a 125 Mbps stream from 25 MHz nibbles would.

Top module: `tx5b_encoder`

## Requirements
- R1: While transmit-enable is low and no end delimiter is pending, every group sent is IDLE `11111`.
- R2: At the first nibble where transmit-enable is high after an idle period, the group /J/ `11000` is sent, and the next group is always /K/ `10001`. Data and error on those two nibbles are ignored.
- R3: Data nibbles after /K/ are encoded 0..F as `11110 01001 10100 10101 01010 01011 01110 01111 10010 10011 10110 10111 11010 11011 11100 11101`.
- R4: A data nibble taken with transmit-error high is sent as /H/ `00100`.
- R5: At the first nibble where transmit-enable is low after data, /T/ `01101` is sent, and the next group is always /R/ `00111`.
- R6: If transmit-enable falls before /K/ has been sent, a full /J/ /K/ pair is sent first, followed by /T/ /R/.
- R7: Each group is sent MSB first, one bit per `bit_en`. `nib_take` is high exactly when the next `bit_en` starts a new group. The inputs are sampled only on that edge, and the first `bit_en` after reset starts a group.
- R8: `tx_bit` is NRZI: it toggles for a code bit of 1 and holds for 0.
- R9: After reset, `tx_bit` is 0, `tx_stb` is 0, `nib_take` is 1, and the encoder is in the idle state.
- R10: `tx_stb` is high for exactly the cycle after each `bit_en`. Without `bit_en`, `tx_bit` holds its value.
- R11: If transmit-enable is high at the nibble right after /R/, a new /J/ /K/ starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advance one serial bit time |
| tx_en | input | 1 | Transmit enable, sampled at group start |
| txd | input | 4 | Transmit nibble |
| tx_er | input | 1 | Transmit error for the nibble |
| nib_take | output | 1 | Next `bit_en` consumes the inputs |
| tx_bit | output | 1 | NRZI serial line bit |
| tx_stb | output | 1 | `tx_bit` updated this cycle |

## Verification
Directed frames cover several cases: a one-nibble frame, which separates a correct complete /J/ /K/ from a truncated start; a two-nibble frame, where the end delimiter directly follows /K/; a frame that walks all sixteen data values plus an error nibble; and a frame that restarts right after /R/. Random frames of mixed lengths, gaps and error flags then run under an irregular `bit_en` pattern, which separates group timing from strobe timing. Between group starts the inputs are changed at random, so a design that samples them at any other time shows up as a wrong line bit.

// File: rtl/tx5b_pkg.sv
package tx5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_J, ST_K, ST_DATA, ST_T, ST_R
  } enc_st_e;

  localparam logic [SYM_W-1:0] SYM_I = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_H = 5'b00100;

  function automatic logic [SYM_W-1:0] data_sym(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: data_sym = 5'b11110;
      4'h1: data_sym = 5'b01001;
      4'h2: data_sym = 5'b10100;
      4'h3: data_sym = 5'b10101;
      4'h4: data_sym = 5'b01010;
      4'h5: data_sym = 5'b01011;
      4'h6: data_sym = 5'b01110;
      4'h7: data_sym = 5'b01111;
      4'h8: data_sym = 5'b10010;
      4'h9: data_sym = 5'b10011;
      4'hA: data_sym = 5'b10110;
      4'hB: data_sym = 5'b10111;
      4'hC: data_sym = 5'b11010;
      4'hD: data_sym = 5'b11011;
      4'hE: data_sym = 5'b11100;
      default: data_sym = 5'b11101;
    endcase
  endfunction
endpackage

// File: rtl/tx5b_sym_enc.sv
module tx5b_sym_enc
  import tx5b_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int SW = SYM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          tx_en,
  input  logic [NW-1:0] txd,
  input  logic          tx_er,
  output logic [SW-1:0] sym
);
  enc_st_e st_q, st_d;

  always_comb begin
    sym  = SYM_I;
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_R: begin
        if (tx_en) begin
          sym  = SYM_J;
          st_d = ST_J;
        end else begin
          sym  = SYM_I;
          st_d = ST_IDLE;
        end
      end
      ST_J: begin
        sym  = SYM_K;
        st_d = ST_K;
      end
      ST_K, ST_DATA: begin
        if (tx_en) begin
          sym  = tx_er ? SYM_H : data_sym(txd);
          st_d = ST_DATA;
        end else begin
          sym  = SYM_T;
          st_d = ST_T;
        end
      end
      ST_T: begin
        sym  = SYM_R;
        st_d = ST_R;
      end
      default: begin
        sym  = SYM_I;
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else if (load) st_q <= st_d;
  end

  p_k_follows_j_r2: assert property (@(posedge clk) disable iff (rst)
    (load && st_q == ST_J) |=> (st_q == ST_K));
  p_err_sym_r4: assert property (@(posedge clk) disable iff (rst)
    (load && tx_en && tx_er && (st_q == ST_K || st_q == ST_DATA)) |-> (sym == SYM_H));
  p_end_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (load && st_q == ST_T) |-> (sym == SYM_R));
  p_idle_sym_r1: assert property (@(posedge clk) disable iff (rst)
    (load && !tx_en && (st_q == ST_IDLE || st_q == ST_R)) |-> (sym == SYM_I));
endmodule

// File: rtl/tx5b_ser.sv
module tx5b_ser #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic [SW-1:0] sym_in,
  output logic          load,
  output logic          nib_take,
  output logic          tx_bit,
  output logic          tx_stb
);
  localparam int IDX_W = $clog2(SW);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SW - 1);

  logic [IDX_W-1:0] idx_q;
  logic             take_q;
  logic [SW-1:0]    sh_q;
  logic             nrz_q;
  logic             line_q;
  logic             stb_q;
  logic             cur;

  assign load     = bit_en && take_q;
  assign cur      = load ? sym_in[SW-1] : sh_q[SW-1];
  assign nib_take = take_q;
  assign tx_bit   = line_q;
  assign tx_stb   = stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= LAST;
      take_q <= 1'b1;
      sh_q   <= '0;
      nrz_q  <= 1'b0;
      line_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= bit_en;
      if (bit_en) begin
        if (load) begin
          idx_q  <= '0;
          take_q <= 1'b0;
          sh_q   <= {sym_in[SW-2:0], 1'b0};
        end else begin
          idx_q  <= idx_q + 1'b1;
          take_q <= (idx_q == LAST - 1'b1);
          sh_q   <= {sh_q[SW-2:0], 1'b0};
        end
        nrz_q  <= cur;
        line_q <= line_q ^ cur;
      end
    end
  end

  p_nrzi_r8: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> ((tx_bit ^ $past(tx_bit)) == nrz_q));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !tx_stb |-> $stable(tx_bit));
  p_take_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (!nib_take && tx_stb));
endmodule

// File: rtl/tx5b_encoder.sv
module tx5b_encoder
  import tx5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  input  logic             tx_er,
  output logic             nib_take,
  output logic             tx_bit,
  output logic             tx_stb
);
  logic             load;
  logic [SYM_W-1:0] sym;

  tx5b_sym_enc #(.NW(NIB_W), .SW(SYM_W)) enc_i (
    .clk(clk), .rst(rst), .load(load), .tx_en(tx_en),
    .txd(txd), .tx_er(tx_er), .sym(sym)
  );

  tx5b_ser #(.SW(SYM_W)) ser_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sym_in(sym),
    .load(load), .nib_take(nib_take), .tx_bit(tx_bit), .tx_stb(tx_stb)
  );
endmodule

// File: tb/tx5b_encoder_tb_top.sv
`timescale 1ns/1ps
module tx5b_encoder_tb_top;
  localparam int NG = 2500;

  logic clk = 1'b0;
  logic rst, bit_en, tx_en, tx_er;
  logic [3:0] txd;
  logic nib_take, tx_bit, tx_stb;

  always #2.5 clk = ~clk;

  tx5b_encoder dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_en(tx_en), .txd(txd),
    .tx_er(tx_er), .nib_take(nib_take), .tx_bit(tx_bit), .tx_stb(tx_stb)
  );

  int n_chk = 0, n_fail = 0;
  bit timeout = 1'b0;
  logic [5:0] stim [0:NG-1];
  int ns = 0;

  // model state: 0 idle, 1 J, 2 K, 3 data, 4 T, 5 R
  int m_st = 0;
  logic [4:0] m_sh = '0;
  int m_cnt = 0;
  logic m_line = 1'b0;
  string m_tag = "R9";
  bit early = 1'b0;
  logic prev_ben = 1'b0;

  function automatic logic [4:0] d5(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                          5'b01010, 5'b01011, 5'b01110, 5'b01111,
                          5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input bit en, input bit er, input logic [3:0] d);
    if (ns < NG) begin
      stim[ns] = {en, er, d};
      ns++;
    end
  endtask

  // model of one group start; returns code, updates state and tag
  task automatic model_load(input logic [5:0] s, output logic [4:0] code);
    bit en = s[5], er = s[4];
    case (m_st)
      0, 5: if (en) begin
              code = 5'b11000; m_tag = (m_st == 5) ? "R11" : "R2"; m_st = 1; early = 1'b0;
            end else begin
              code = 5'b11111; m_tag = "R1"; m_st = 0;
            end
      1: begin
           code = 5'b10001; early = !en; m_tag = early ? "R6" : "R2"; m_st = 2;
         end
      2, 3: if (en) begin
              code = er ? 5'b00100 : d5(s[3:0]); m_tag = er ? "R4" : "R3"; m_st = 3;
            end else begin
              code = 5'b01101; m_tag = (m_st == 2 && early) ? "R6" : "R5"; m_st = 4;
            end
      default: begin code = 5'b00111; m_tag = "R5"; m_st = 5; end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    timeout = 1'b1;
  end

  initial begin
    logic [4:0] code;
    logic b;
    bit ben;
    // directed
    repeat (3) push(0, 0, 4'h0);
    push(1, 1, 4'h5); repeat (4) push(0, 0, 4'h0);          // R6 one-nibble frame, er ignored
    push(1, 0, 4'h5); push(1, 0, 4'h5); repeat (3) push(0, 0, 4'h0);
    push(1, 0, 4'h5); push(1, 0, 4'h5);
    for (int i = 0; i < 16; i++) push(1, 0, 4'(i));
    push(1, 1, 4'h5); push(1, 0, 4'hD);
    repeat (2) push(0, 0, 4'h0);
    repeat (4) push(1, 0, 4'hA);                             // R11 restart right after R
    repeat (3) push(0, 0, 4'h0);
    // random frames
    while (ns < NG) begin
      int len = 1 + ($urandom % 20);
      int gap = $urandom % 7;
      for (int i = 0; i < len; i++) push(1, ($urandom % 16) == 0, 4'($urandom));
      for (int i = 0; i < gap; i++) push(0, 0, 4'($urandom));
    end

    rst = 1'b1; bit_en = 1'b0; tx_en = 1'b0; tx_er = 1'b0; txd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_bit === 1'b0, "R9 tx_bit", tx_bit, 0);
    chk(tx_stb === 1'b0, "R9 tx_stb", tx_stb, 0);
    chk(nib_take === 1'b1, "R9 nib_take", nib_take, 1);
    rst = 1'b0;

    for (int g = 0; g < NG && !timeout; ) begin
      @(negedge clk);
      if (prev_ben) chk(tx_stb === 1'b1, "R10 strobe", tx_stb, 1);
      else          chk(tx_stb === 1'b0, "R10 strobe", tx_stb, 0);
      chk(tx_bit === m_line, {m_tag, " R7 R8 line"}, tx_bit, m_line);
      chk(nib_take === (m_cnt == 0), "R7 nib_take", nib_take, m_cnt == 0);
      ben = ($urandom % 4) != 0;
      if (m_cnt == 0) begin
        tx_en = stim[g][5]; tx_er = stim[g][4]; txd = stim[g][3:0];
      end else begin
        tx_en = 1'($urandom); tx_er = 1'($urandom); txd = 4'($urandom);
      end
      if (ben) begin
        if (m_cnt == 0) begin
          model_load(stim[g], code);
          m_sh = code; m_cnt = 5; g++;
        end
        b = m_sh[4];
        m_sh = {m_sh[3:0], 1'b0};
        m_cnt--;
        m_line = m_line ^ b;
      end
      bit_en = ben;
      prev_ben = ben;
    end
    @(negedge clk);
    chk(tx_bit === m_line, {m_tag, " R8 final"}, tx_bit, m_line);
    if (timeout) chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule